// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This peripheral holds a 16-bit up-counter that software reaches through an 8-bit register port. The counter has two sources. In timer mode it advances on an instruction-cycle tick, which is one system clock in every four. In counter mode it advances on rising edges of an external clock pin. The pin first passes through a two-flop synchronizer and a rising-edge detector. A 2-bit divider field places a prescaler of 1, 2, 4 or 8 in front of the counter. In counter mode an alignment bit selects how each prescaled edge reaches the counter. In aligned mode an edge waits for the next instruction tick. In direct mode it steps the counter on the system clock where it appears.

An aligner state machine handles aligned mode. It has two states. `AL_IDLE` means no step is pending. `AL_HELD` means a prescaled edge arrived off-tick and is waiting. The transitions are:
- IDLE→HELD: a prescaled edge arrives with no tick in that cycle.
- HELD→IDLE: on the next tick, which also steps the counter.
- IDLE→IDLE with a step: a prescaled edge arrives in a tick cycle.
- Any state→IDLE: the aligner is inactive.
Edges that arrive while in HELD merge into the pending step.

A compare-match trigger input can clear the count when the timer is assigned to it. Overflow sets a sticky interrupt flag. A shared high-byte buffer makes 16-bit reads and writes atomic. Reading the low byte copies the live high byte into the buffer. Writing the low byte loads the buffer and the written byte into the counter together.

Top module: `tick_timer16`

## Requirements
- R1: After reset the count, the high-byte buffer, the control register (address 2) and the flag are all zero, and `irq_o` is low.
- R2: With the source bit clear (control bit 1 = 0) and run set (bit 0 = 1), the count advances only in instruction-tick cycles, once per tick at a divide of 1.
- R3: The divider field (control bits 4:3) divides the selected source by 1, 2, 4 or 8 for the codes 0, 1, 2, 3.
- R4: With run clear, the count holds its value.
- R5: With the source bit set and the direct bit set (control bit 2 = 1), each rising edge on `ext_clk_i` is counted once at a divide of 1.
- R6: With the source bit set and the direct bit clear, each prescaled edge is counted once, and the count changes only in instruction-tick cycles.
- R7: An increment from 0xFFFF wraps the count to 0x0000 and sets the flag, which drives `irq_o`.
- R8: The flag (address 3, bit 0) stays set until a write with bit 0 = 0. A write with bit 0 = 1 has no effect. An overflow in the same cycle as a clearing write leaves the flag set.
- R9: A `trig_i` pulse clears the count only when the assign bit (control bit 5) is set. The trigger takes priority over a low-byte write.
- R10: A read strobe on the low byte (address 0) latches the live high byte into the buffer, which address 1 returns unchanged until the next latch or high write.
- R11: A write to address 1 changes only the buffer. A write to address 0 loads {buffer, data} into the count.
- R12: A low-byte write takes priority over an increment in the same cycle.
- R13: The prescaler restarts on every low-byte write and on every control write that changes the divider field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| trig_i | input | 1 | Compare-match clear trigger, one-cycle pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 low, 1 high buffer, 2 control, 3 flag |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default parameters: an 8-bit bus, a 16-bit count, an instruction tick every four clocks and two synchronizer stages. With a 16-bit count, overflow is reached in a few cycles by loading 0xFFFF or 0xFFFE through the buffered write. The fixed four-clock tick lets the bench measure exact divide ratios over windows that are multiples of 4·divide. The known three-clock pin-to-counter latency lets the bench place a register write or a flag clear in the exact cycle of an external increment.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int PSEL_W = 2;

    typedef enum logic [1:0] {
        A_CNT_LO = 2'd0,
        A_CNT_HI = 2'd1,
        A_CTRL   = 2'd2,
        A_FLAG   = 2'd3
    } reg_addr_e;

    // bit5 trig_own, bits4:3 psel, bit2 direct, bit1 ext_sel, bit0 run
    typedef struct packed {
        logic              trig_own;
        logic [PSEL_W-1:0] psel;
        logic              direct;
        logic              ext_sel;
        logic              run;
    } ctrl_t;

    typedef enum logic {
        AL_IDLE = 1'b0,
        AL_HELD = 1'b1
    } align_st_e;

endpackage

// File: rtl/tmr16_edge_det.sv
module tmr16_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DW = (1 << SEL_W) - 1;

    logic [DW-1:0] cnt_q;
    logic [DW:0]   one_sh;
    logic [DW-1:0] lim;

    always_comb begin
        one_sh = {{DW{1'b0}}, 1'b1} << sel_i;
        lim    = one_sh[DW-1:0] - DW'(1);
    end

    assign tick_o = step_i & (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (step_i) cnt_q <= tick_o ? '0 : cnt_q + DW'(1);
    end
endmodule

// File: rtl/tmr16_align.sv
module tmr16_align
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tick_i,
    input  logic ev_i,
    output logic step_o
);
    align_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AL_IDLE: if (active_i && ev_i && !tick_i) st_d = AL_HELD;
            AL_HELD: if (!active_i || tick_i)         st_d = AL_IDLE;
            default:                                  st_d = AL_IDLE;
        endcase
    end

    always_comb begin
        step_o = 1'b0;
        unique case (st_q)
            AL_IDLE: step_o = active_i & ev_i & tick_i;
            AL_HELD: step_o = active_i & tick_i;
            default: step_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
    import tmr16_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int CYC_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             trig_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [1:0]       addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             irq_o
);
    localparam int CNT_W  = 2 * BUS_W;
    localparam int PH_W   = $clog2(CYC_DIV);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [PH_W-1:0]  phase_q;
    logic             instr_tick, ext_rise, src_evt, ps_tick, ps_clr;
    logic             align_active, align_step, cnt_inc;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] hbuf_q;
    ctrl_t            ctrl_q, ctrl_wr_val;
    logic             flag_q;
    logic             lo_wr, hi_wr, ctrl_wr, flag_clr, lo_rd, trig_hit, ovf;
    reg_addr_e        addr;

    assign addr        = reg_addr_e'(addr_i);
    assign lo_wr       = wr_en_i && addr == A_CNT_LO;
    assign hi_wr       = wr_en_i && addr == A_CNT_HI;
    assign ctrl_wr     = wr_en_i && addr == A_CTRL;
    assign flag_clr    = wr_en_i && addr == A_FLAG && !wdata_i[0];
    assign lo_rd       = rd_en_i && addr == A_CNT_LO;
    assign ctrl_wr_val = ctrl_t'(wdata_i[CTRL_W-1:0]);
    assign trig_hit    = trig_i && ctrl_q.trig_own;

    // instruction-cycle phase
    assign instr_tick = (phase_q == PH_W'(CYC_DIV - 1));
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= instr_tick ? '0 : phase_q + PH_W'(1);
    end

    tmr16_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_clk_i),
        .rise_o (ext_rise)
    );

    assign src_evt = ctrl_q.ext_sel ? ext_rise : instr_tick;
    assign ps_clr  = lo_wr || (ctrl_wr && ctrl_wr_val.psel != ctrl_q.psel);

    tmr16_prescale #(.SEL_W(PSEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ps_clr),
        .step_i(ctrl_q.run & src_evt),
        .sel_i (ctrl_q.psel),
        .tick_o(ps_tick)
    );

    assign align_active = ctrl_q.run && ctrl_q.ext_sel && !ctrl_q.direct;

    tmr16_align u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(align_active),
        .tick_i  (instr_tick),
        .ev_i    (ps_tick),
        .step_o  (align_step)
    );

    assign cnt_inc = align_active ? align_step : ps_tick;
    assign ovf     = cnt_inc && (&cnt_q) && !trig_hit && !lo_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hbuf_q <= '0;
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (trig_hit)     cnt_q <= '0;
            else if (lo_wr)   cnt_q <= {hbuf_q, wdata_i};
            else if (cnt_inc) cnt_q <= cnt_q + CNT_W'(1);

            if (hi_wr)        hbuf_q <= wdata_i;
            else if (lo_rd)   hbuf_q <= cnt_q[CNT_W-1:BUS_W];

            if (ctrl_wr)      ctrl_q <= ctrl_wr_val;

            if (ovf)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr)
            A_CNT_LO: rdata_o = cnt_q[BUS_W-1:0];
            A_CNT_HI: rdata_o = hbuf_q;
            A_CTRL:   rdata_o = BUS_W'(ctrl_q);
            A_FLAG:   rdata_o = BUS_W'(flag_q);
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = flag_q;
endmodule

// File: rtl/tick_timer16_chk.sv
module tick_timer16_chk #(
    parameter int BUS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic [1:0]         addr_i,
    input logic [BUS_W-1:0]   wdata_i,
    input logic               trig_i,
    input logic [2*BUS_W-1:0] cnt_q,
    input logic               flag_q,
    input logic               run,
    input logic               ext_sel,
    input logic               direct,
    input logic               trig_own,
    input logic               cnt_inc,
    input logic               instr_tick
);
    // R9
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i && trig_own |=> cnt_q == '0);

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc && (&cnt_q) && !(trig_i && trig_own) && !(wr_en_i && addr_i == 2'd0)
        |=> flag_q && cnt_q == '0);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(wr_en_i && addr_i == 2'd3 && !wdata_i[0]) |=> flag_q);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_en_i && !trig_i |=> $stable(cnt_q));

    // R6
    sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc && run && ext_sel && !direct |-> instr_tick);

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc && !ext_sel |-> instr_tick);

    // R12
    write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && addr_i == 2'd0 && !(trig_i && trig_own)
        |=> cnt_q[BUS_W-1:0] == $past(wdata_i));
endmodule

bind tick_timer16 tick_timer16_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .trig_i    (trig_i),
    .cnt_q     (cnt_q),
    .flag_q    (flag_q),
    .run       (ctrl_q.run),
    .ext_sel   (ctrl_q.ext_sel),
    .direct    (ctrl_q.direct),
    .trig_own  (ctrl_q.trig_own),
    .cnt_inc   (cnt_inc),
    .instr_tick(instr_tick)
);

// File: tb/tick_timer16_tb.sv
`timescale 1ns/1ps
module tick_timer16_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_i = 1'b0, trig_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int    n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    logic [7:0] a, b;

    always #2.5 clk = ~clk;

    tick_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .trig_i(trig_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // behavioural reference model
    int          m_cyc, m_pc, m_div, n_pc;
    bit          m_s1, m_s2, m_s3, m_held, m_flag;
    bit [15:0]   m_cnt;
    bit [7:0]    m_hbuf;
    bit [5:0]    m_ctrl;
    bit t_en, t_cs, t_dir, t_asg, t_tick, t_src, t_pst, t_act, t_inc, t_lw, t_trg, n_held;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cyc = 0; m_pc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_held = 0;
            m_flag = 0; m_cnt = 0; m_hbuf = 0; m_ctrl = 0;
        end else begin
            t_en = m_ctrl[0]; t_cs = m_ctrl[1]; t_dir = m_ctrl[2]; t_asg = m_ctrl[5];
            m_div = 1 << m_ctrl[4:3];
            t_tick = (m_cyc % 4) == 3;
            t_src = t_cs ? (m_s2 && !m_s3) : t_tick;
            t_pst = t_en && t_src && (m_pc == m_div - 1);
            t_act = t_en && t_cs && !t_dir;
            t_inc = t_act ? (t_tick && (m_held || t_pst)) : t_pst;
            t_lw  = wr_en_i && addr_i == 2'd0;
            t_trg = trig_i && t_asg;
            n_held = t_act && (m_held || t_pst) && !t_tick;
            if (t_lw || (wr_en_i && addr_i == 2'd2 && wdata_i[4:3] != m_ctrl[4:3])) n_pc = 0;
            else if (t_en && t_src) n_pc = t_pst ? 0 : m_pc + 1;
            else n_pc = m_pc;
            if (t_inc && m_cnt == 16'hFFFF && !t_trg && !t_lw) m_flag = 1;
            else if (wr_en_i && addr_i == 2'd3 && !wdata_i[0]) m_flag = 0;
            if (t_trg) m_cnt = 0;
            else if (t_lw) m_cnt = {m_hbuf, wdata_i};
            else if (t_inc) m_cnt = m_cnt + 16'd1;
            if (wr_en_i && addr_i == 2'd1) m_hbuf = wdata_i;
            else if (rd_en_i && addr_i == 2'd0) m_hbuf = m_cnt_prev_hi;
            if (wr_en_i && addr_i == 2'd2) m_ctrl = wdata_i[5:0];
            m_held = n_held; m_pc = n_pc;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_i;
            m_cyc++;
        end
    end

    // high byte before this edge's update, for the read latch
    bit [7:0] m_cnt_prev_hi;
    always @(negedge clk) m_cnt_prev_hi = m_cnt[15:8];

    function automatic logic [7:0] exp_rdata(input logic [1:0] ad);
        case (ad)
            2'd0: return m_cnt[7:0];
            2'd1: return m_hbuf;
            2'd2: return {2'b00, m_ctrl};
            default: return {7'd0, m_flag};
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk({cur_req, " rdata"}, rdata_o, exp_rdata(addr_i));
            chk({cur_req, " irq"}, irq_o, m_flag);
        end
    end

    task automatic wr(input logic [1:0] ad, input logic [7:0] d);
        @(negedge clk); wr_en_i = 1; addr_i = ad; wdata_i = d;
        @(negedge clk); wr_en_i = 0;
    endtask

    task automatic rd(input logic [1:0] ad, output logic [7:0] d);
        @(negedge clk); rd_en_i = 1; addr_i = ad; #1 d = rdata_o;
        @(negedge clk); rd_en_i = 0;
    endtask

    task automatic peek(input logic [1:0] ad, output logic [7:0] d);
        @(negedge clk); addr_i = ad; #1 d = rdata_o;
    endtask

    task automatic pulse();
        @(negedge clk); ext_clk_i = 1;
        repeat (2) @(negedge clk);
        @(negedge clk); ext_clk_i = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        peek(2, a); chk("R1 ctrl", a, 0);
        peek(3, a); chk("R1 flag", a, 0);
        peek(0, a); chk("R1 cnt lo", a, 0);
        peek(1, a); chk("R1 hbuf", a, 0);
        chk("R1 irq", irq_o, 0);

        // R2 / R3 timer mode at every divide
        for (int ps = 0; ps < 4; ps++) begin
            cur_req = (ps == 0) ? "R2" : "R3";
            wr(2, 8'h01 | 8'(ps << 3));
            peek(0, a);
            repeat (20 * (1 << ps) - 1) @(negedge clk);
            peek(0, b);
            chk((ps == 0) ? "R2 ticks" : "R3 timer divide", 8'(b - a), 5);
        end

        // R4 hold when stopped
        cur_req = "R4";
        wr(2, 8'h00);
        peek(0, a); repeat (40) @(negedge clk); peek(0, b);
        chk("R4 hold", b, a);

        // R5 direct external counting
        cur_req = "R5";
        wr(2, 8'h07);
        peek(0, a);
        repeat (6) pulse();
        repeat (8) @(negedge clk);
        peek(0, b); chk("R5 edges", 8'(b - a), 6);

        cur_req = "R3";
        wr(2, 8'h17);
        peek(0, a);
        repeat (8) pulse();
        repeat (8) @(negedge clk);
        peek(0, b); chk("R3 ext divide 4", 8'(b - a), 2);

        // R6 aligned external counting
        cur_req = "R6";
        wr(2, 8'h03);
        peek(0, a);
        repeat (5) pulse();
        repeat (8) @(negedge clk);
        peek(0, b); chk("R6 edges", 8'(b - a), 5);

        // R7 overflow
        cur_req = "R7";
        wr(2, 8'h01);
        wr(1, 8'hFF); wr(0, 8'hFE);
        repeat (16) @(negedge clk);
        chk("R7 irq", irq_o, 1);
        peek(0, a); chk("R7 wrapped", a < 8, 1);

        // R8 sticky flag
        cur_req = "R8";
        wr(2, 8'h00);
        repeat (20) @(negedge clk);
        chk("R8 sticky", irq_o, 1);
        wr(3, 8'h01); chk("R8 write one", irq_o, 1);
        wr(3, 8'h00); chk("R8 cleared", irq_o, 0);

        // R8 set wins over clear in same cycle
        wr(2, 8'h07);
        wr(1, 8'hFF); wr(0, 8'hFF);
        @(negedge clk); ext_clk_i = 1;
        @(negedge clk);
        @(negedge clk); wr_en_i = 1; addr_i = 2'd3; wdata_i = 8'h00;
        @(negedge clk); wr_en_i = 0; ext_clk_i = 0;
        #1 chk("R8 set wins", irq_o, 1);
        peek(0, a); chk("R7 wrap to zero", a, 0);
        wr(3, 8'h00);

        // R12 write beats increment
        cur_req = "R12";
        @(negedge clk); ext_clk_i = 1;
        @(negedge clk);
        @(negedge clk); wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'h40;
        @(negedge clk); wr_en_i = 0; ext_clk_i = 0;
        peek(0, a); chk("R12 write wins", a, 8'h40);

        // R9 trigger
        cur_req = "R9";
        wr(2, 8'h00);
        wr(1, 8'h12); wr(0, 8'h34);
        @(negedge clk); trig_i = 1;
        @(negedge clk); trig_i = 0;
        peek(0, a); chk("R9 unassigned ignored", a, 8'h34);
        wr(2, 8'h20);
        @(negedge clk); trig_i = 1;
        @(negedge clk); trig_i = 0;
        rd(0, a); chk("R9 cleared lo", a, 0);
        peek(1, a); chk("R9 cleared hi", a, 0);
        wr(1, 8'h55);
        @(negedge clk); trig_i = 1; wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'h66;
        @(negedge clk); trig_i = 0; wr_en_i = 0;
        rd(0, a); chk("R9 beats write lo", a, 0);
        peek(1, a); chk("R9 beats write hi", a, 0);

        // R10 atomic read
        cur_req = "R10";
        wr(2, 8'h01);
        wr(1, 8'h00); wr(0, 8'hFD);
        rd(0, a);
        repeat (20) @(negedge clk);
        peek(1, b); chk("R10 buffer frozen", b, 0);
        rd(0, a); peek(1, b); chk("R10 relatch", b, 1);

        // R11 buffered write
        cur_req = "R11";
        wr(2, 8'h00);
        wr(1, 8'h11); wr(0, 8'h22); wr(1, 8'h5A);
        rd(0, a); chk("R11 lo", a, 8'h22);
        peek(1, b); chk("R11 hi untouched", b, 8'h11);
        wr(1, 8'h77); wr(0, 8'h33);
        rd(0, a); chk("R11 lo load", a, 8'h33);
        peek(1, b); chk("R11 hi load", b, 8'h77);

        // R13 prescaler restart
        cur_req = "R13";
        wr(2, 8'h0F);
        wr(1, 8'h00); wr(0, 8'h00);
        pulse();
        wr(0, 8'h00);
        pulse();
        peek(0, a); chk("R13 cleared by write", a, 0);
        pulse();
        peek(0, a); chk("R13 divide 2 tick", a, 1);
        pulse();
        wr(2, 8'h17); wr(2, 8'h0F);
        pulse();
        peek(0, a); chk("R13 cleared by select", a, 1);
        pulse();
        peek(0, a); chk("R13 after select", a, 2);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule